// File: doc/BRIEF.md
# PMIC Enable Power Sequencer

This block owns the enable line of an external power-management IC. Software programs a control word holding an enable request and a status-wait limit. The block turns that request into the real enable output. It then waits for the PMIC to report that its rails are good, and it reports the enabled state it has actually reached. That state is kept apart from the software bit, because three other agents also have a say: deep-sleep entry and wakeup events, a debugger that asks for the chip to stay powered, and a watchdog on the status-good wait.

A prescaler divides the block clock, which comes from the internal oscillator, into a coarse tick. With the default divider, one tick is 128 µs of nominal oscillator time. A nonzero wait limit N allows N ticks for the status-good input to rise after each switch-on. If it does not rise in time, the block drops the enable and raises a reset request. That request stays high until the block is reset. A deep-sleep request that arrives while a switch-on is still in progress is held until the switch-on completes, so the two sequences never overlap.

Top module: `pmic_en_seq`

## Requirements
- R1: The control word reads back with the wait limit in bits 7:0 and the software enable in bit 31. All other bits read 0, and the whole word is 0 after reset.
- R2: A write that sets bit 31 while `cfgDone` is low leaves the enable bit at 0 and does not turn the PMIC on.
- R3: With no sequence active, setting the software enable makes `pmicEnOut` and `seqBusy` rise on the second clock edge after the write. When `pmicOk` is seen high during the wait, the next edge clears `seqBusy` and sets `pmicActive`.
- R4: A wait limit of 0 disables the wait timeout, so `timeoutRst` never rises however long `pmicOk` stays low.
- R5: With a wait limit of N > 0 and `pmicOk` held low, `timeoutRst` rises TICK_DIV·N+1 edges after `pmicEnOut` rose, and `pmicEnOut` falls in the same cycle. Both states hold until reset.
- R6: While `dbgPwrUpReq` is high, an active PMIC stays enabled. Clearing the software enable does not turn it off, and a deep-sleep request is dropped.
- R7: `dbgPwrUpReq` alone never turns on a PMIC that is off.
- R8: When `dbgPwrUpReq` falls while the software enable is 0, the PMIC is turned off on the next edge.
- R9: A deep-sleep request while active turns `pmicEnOut` off on the next edge. A later wakeup with the software enable set turns it back on and restarts the status wait, with `seqBusy` high.
- R10: A deep-sleep request during the status wait is held. It turns the PMIC off one edge after the edge that sets `pmicActive`.
- R11: Clearing the software enable while active, with no debugger request, turns `pmicEnOut` off on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oscillator clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgDone | input | 1 | One-time configured flag that gates the enable bit |
| swWr | input | 1 | Write strobe for the control word |
| swWrData | input | 32 | Control word write data |
| dbgPwrUpReq | input | 1 | Debugger keep-powered request |
| sleepEnterReq | input | 1 | Deep-sleep entry event, one-cycle pulse |
| wakeupReq | input | 1 | Deep-sleep wakeup event, one-cycle pulse |
| pmicOk | input | 1 | Status-good from the PMIC |
| ctlRdData | output | 32 | Control word read-back |
| pmicEnOut | output | 1 | Enable line to the PMIC |
| pmicActive | output | 1 | PMIC enabled and its status confirmed |
| seqBusy | output | 1 | Switch-on sequence waiting for status-good |
| timeoutRst | output | 1 | Reset request after a status-wait timeout |

## Verification
The hardest state to reach is a deep-sleep request that lands inside the status wait and must survive until the PMIC reports good. Getting there takes a full sleep-and-wake round trip, so that the wait is re-entered with the enable set. The stimulus holds `pmicOk` low, pulses the sleep event while `seqBusy` is high, and only then releases status-good. The timeout boundary is reached with a small divider, and the bench samples exactly one edge before and one edge after the expected expiry.

// File: rtl/pmic_seq_pkg.sv
package pmic_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_WAIT,
    ST_ON,
    ST_SLEEP,
    ST_FAULT
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadWait;
    logic runWait;
  } waitCtl_t;

endpackage

// File: rtl/pmic_seq_dp.sv
module pmic_seq_dp
  import pmic_seq_pkg::*;
#(
  parameter int REG_W    = 32,
  parameter int TMO_W    = 8,
  parameter int EN_BIT   = 31,
  parameter int TICK_DIV = 1024
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgDone,
  input  logic             swWr,
  input  logic [REG_W-1:0] swWrData,
  input  waitCtl_t         waitCtl,
  output logic             swEn,
  output logic [TMO_W-1:0] tmoVal,
  output logic [REG_W-1:0] ctlRdData,
  output logic             waitExpired
);

  localparam int PRESC_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRESC_W-1:0] PRESC_LAST = PRESC_W'(TICK_DIV - 1);

  logic [PRESC_W-1:0] prescCnt;
  logic [TMO_W-1:0]   waitCnt;
  logic               tickHit;
  logic               unusedBits;

  assign unusedBits = ^swWrData[EN_BIT-1:TMO_W];

  // control word storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      swEn   <= 1'b0;
      tmoVal <= '0;
    end else if (swWr) begin
      swEn   <= swWrData[EN_BIT] & cfgDone;
      tmoVal <= swWrData[TMO_W-1:0];
    end
  end

  always_comb begin
    ctlRdData              = '0;
    ctlRdData[TMO_W-1:0]   = tmoVal;
    ctlRdData[EN_BIT]      = swEn;
  end

  // oscillator prescaler and status-wait down-counter
  assign tickHit = (prescCnt == PRESC_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prescCnt <= '0;
      waitCnt  <= '0;
    end else if (waitCtl.loadWait) begin
      prescCnt <= '0;
      waitCnt  <= tmoVal;
    end else if (waitCtl.runWait) begin
      prescCnt <= tickHit ? '0 : prescCnt + 1'b1;
      if (tickHit && waitCnt != '0) waitCnt <= waitCnt - 1'b1;
    end
  end

  assign waitExpired = waitCtl.runWait && (tmoVal != '0) && (waitCnt == '0);

  AST_EN_NEEDS_CFG: assert property (@(posedge clk) disable iff (!rstN)
    (swWr && !cfgDone) |=> !swEn); // R2

  AST_RDBACK_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    ctlRdData[EN_BIT-1:TMO_W] == '0); // R1

endmodule

// File: rtl/pmic_seq_ctrl.sv
module pmic_seq_ctrl
  import pmic_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     swEn,
  input  logic     dbgReq,
  input  logic     sleepReq,
  input  logic     wakeReq,
  input  logic     pmicOk,
  input  logic     waitExpired,
  output waitCtl_t waitCtl,
  output logic     pmicEnOut,
  output logic     pmicActive,
  output logic     seqBusy,
  output logic     timeoutRst
);

  seqState_t state, nextState;
  logic      sleepPend;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_OFF:   if (swEn) nextState = ST_WAIT;
      ST_WAIT: begin
        if (pmicOk)                nextState = ST_ON;
        else if (waitExpired)      nextState = ST_FAULT;
        else if (!swEn && !dbgReq) nextState = ST_OFF;
      end
      ST_ON: begin
        if (!dbgReq && (sleepReq || sleepPend)) nextState = ST_SLEEP;
        else if (!swEn && !dbgReq)              nextState = ST_OFF;
      end
      ST_SLEEP: if (wakeReq) nextState = swEn ? ST_WAIT : ST_OFF;
      ST_FAULT: nextState = ST_FAULT;
      default:  nextState = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_OFF;
      sleepPend <= 1'b0;
    end else begin
      state     <= nextState;
      // a sleep request is only parked during the status wait
      sleepPend <= (state == ST_WAIT) && (sleepPend || sleepReq);
    end
  end

  assign waitCtl.loadWait = (nextState == ST_WAIT) && (state != ST_WAIT);
  assign waitCtl.runWait  = (state == ST_WAIT);

  assign pmicEnOut  = (state == ST_WAIT) || (state == ST_ON);
  assign pmicActive = (state == ST_ON);
  assign seqBusy    = (state == ST_WAIT);
  assign timeoutRst = (state == ST_FAULT);

  AST_OK_ENDS_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (seqBusy && pmicOk) |=> (pmicActive && !seqBusy)); // R3

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    timeoutRst |=> (timeoutRst && !pmicEnOut)); // R5

  AST_DBG_HOLDS_ON: assert property (@(posedge clk) disable iff (!rstN)
    (pmicActive && dbgReq) |=> pmicActive); // R6

  AST_DBG_NO_TURN_ON: assert property (@(posedge clk) disable iff (!rstN)
    (!pmicEnOut && !swEn) |=> !pmicEnOut); // R7

  AST_RELEASE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (pmicActive && !dbgReq && !swEn) |=> !pmicEnOut); // R8

  AST_SLEEP_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (pmicActive && !dbgReq && sleepReq) |=> !pmicEnOut); // R9

endmodule

// File: rtl/pmic_en_seq.sv
module pmic_en_seq
  import pmic_seq_pkg::*;
#(
  parameter int REG_W    = 32,
  parameter int TMO_W    = 8,
  parameter int EN_BIT   = 31,
  parameter int TICK_DIV = 1024
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgDone,
  input  logic             swWr,
  input  logic [REG_W-1:0] swWrData,
  input  logic             dbgPwrUpReq,
  input  logic             sleepEnterReq,
  input  logic             wakeupReq,
  input  logic             pmicOk,
  output logic [REG_W-1:0] ctlRdData,
  output logic             pmicEnOut,
  output logic             pmicActive,
  output logic             seqBusy,
  output logic             timeoutRst
);

  waitCtl_t         waitCtl;
  logic             swEn;
  logic [TMO_W-1:0] tmoVal;
  logic             waitExpired;

  pmic_seq_dp #(
    .REG_W   (REG_W),
    .TMO_W   (TMO_W),
    .EN_BIT  (EN_BIT),
    .TICK_DIV(TICK_DIV)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .cfgDone    (cfgDone),
    .swWr       (swWr),
    .swWrData   (swWrData),
    .waitCtl    (waitCtl),
    .swEn       (swEn),
    .tmoVal     (tmoVal),
    .ctlRdData  (ctlRdData),
    .waitExpired(waitExpired)
  );

  pmic_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .swEn       (swEn),
    .dbgReq     (dbgPwrUpReq),
    .sleepReq   (sleepEnterReq),
    .wakeReq    (wakeupReq),
    .pmicOk     (pmicOk),
    .waitExpired(waitExpired),
    .waitCtl    (waitCtl),
    .pmicEnOut  (pmicEnOut),
    .pmicActive (pmicActive),
    .seqBusy    (seqBusy),
    .timeoutRst (timeoutRst)
  );

  AST_ZERO_NO_TIMEOUT: assert property (@(posedge clk) disable iff (!rstN)
    (seqBusy && tmoVal == '0) |=> !timeoutRst); // R4

endmodule

// File: tb/pmic_en_seq_tb.sv
module pmic_en_seq_tb;

  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgDone = 1'b0;
  logic        swWr = 1'b0;
  logic [31:0] swWrData = '0;
  logic        dbgPwrUpReq = 1'b0;
  logic        sleepEnterReq = 1'b0;
  logic        wakeupReq = 1'b0;
  logic        pmicOk = 1'b0;
  logic [31:0] ctlRdData;
  logic        pmicEnOut, pmicActive, seqBusy, timeoutRst;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pmic_en_seq #(.TICK_DIV(DIV)) u_dut (
    .clk(clk), .rstN(rstN), .cfgDone(cfgDone), .swWr(swWr), .swWrData(swWrData),
    .dbgPwrUpReq(dbgPwrUpReq), .sleepEnterReq(sleepEnterReq), .wakeupReq(wakeupReq),
    .pmicOk(pmicOk), .ctlRdData(ctlRdData), .pmicEnOut(pmicEnOut),
    .pmicActive(pmicActive), .seqBusy(seqBusy), .timeoutRst(timeoutRst)
  );

  function automatic logic [31:0] expRead(logic [31:0] d, logic cfg);
    return {d[31] & cfg, 23'd0, d[7:0]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wrReg(logic [31:0] d);
    swWr = 1'b1;
    swWrData = d;
    step();
    swWr = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    step(2);
    rstN = 1'b1;
    step();
  endtask

  task automatic pulseOk();
    pmicOk = 1'b1;
    step();
    pmicOk = 1'b0;
  endtask

  task automatic pulseSleep();
    sleepEnterReq = 1'b1;
    step();
    sleepEnterReq = 1'b0;
  endtask

  task automatic pulseWake();
    wakeupReq = 1'b1;
    step();
    wakeupReq = 1'b0;
  endtask

  // software enable with zero wait limit, then status-good
  task automatic bringUp();
    wrReg(32'h8000_0000);
    step();
    pulseOk();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seedVal;
    seedVal = $urandom(32'h1F3);
    step();
    check("R1 reset readback", ctlRdData, 32'h0);
    check("R1 reset enable", {31'd0, pmicEnOut}, 32'd0);
    rstN = 1'b1;
    step();

    // R2: enable bit blocked without configuration
    wrReg(32'h8000_0055);
    check("R2 bit stays 0", ctlRdData, 32'h0000_0055);
    step(2);
    check("R2 no enable", {31'd0, pmicEnOut}, 32'd0);

    // R1: random write/readback
    for (int i = 0; i < 40; i++) begin
      logic [31:0] d;
      logic c;
      d = $urandom;
      c = 1'($urandom % 2);
      cfgDone = c;
      wrReg(d);
      check("R1 random readback", ctlRdData, expRead(d, c));
    end
    cfgDone = 1'b1;
    doReset();

    // R3: switch-on handshake
    wrReg(32'h8000_0000);
    check("R3 not yet on", {31'd0, pmicEnOut}, 32'd0);
    step();
    check("R3 enable on", {30'd0, pmicEnOut, seqBusy}, 32'd3);
    check("R3 not active", {31'd0, pmicActive}, 32'd0);
    pulseOk();
    check("R3 active", {30'd0, pmicActive, seqBusy}, 32'd2);

    // R11: software disable
    wrReg(32'h0);
    check("R11 still on", {31'd0, pmicEnOut}, 32'd1);
    step();
    check("R11 off", {31'd0, pmicEnOut}, 32'd0);

    // R4: zero limit waits forever
    wrReg(32'h8000_0000);
    step();
    step(300);
    check("R4 no reset", {30'd0, timeoutRst, seqBusy}, 32'd1);
    pulseOk();
    wrReg(32'h0);
    step();

    // R5: timeout with limit 3
    wrReg(32'h8000_0003);
    step();
    check("R5 wait started", {31'd0, pmicEnOut}, 32'd1);
    step(DIV * 3);
    check("R5 before expiry", {30'd0, timeoutRst, pmicEnOut}, 32'd1);
    step();
    check("R5 at expiry", {30'd0, timeoutRst, pmicEnOut}, 32'd2);
    step(5);
    check("R5 sticky", {30'd0, timeoutRst, pmicEnOut}, 32'd2);
    doReset();
    check("R5 cleared by reset", {31'd0, timeoutRst}, 32'd0);

    // R6 / R8: debugger keep-alive
    bringUp();
    dbgPwrUpReq = 1'b1;
    wrReg(32'h0);
    step(3);
    check("R6 held on", {30'd0, pmicEnOut, pmicActive}, 32'd3);
    pulseSleep();
    check("R6 sleep dropped", {31'd0, pmicActive}, 32'd1);
    dbgPwrUpReq = 1'b0;
    step();
    check("R8 release off", {31'd0, pmicEnOut}, 32'd0);

    // R7: debugger alone does not turn on
    dbgPwrUpReq = 1'b1;
    step(5);
    check("R7 stays off", {31'd0, pmicEnOut}, 32'd0);
    dbgPwrUpReq = 1'b0;

    // R9: deep-sleep round trip
    bringUp();
    pulseSleep();
    check("R9 sleep off", {31'd0, pmicEnOut}, 32'd0);
    step(3);
    check("R9 stays off", {31'd0, pmicEnOut}, 32'd0);
    pulseWake();
    check("R9 wake rewait", {30'd0, pmicEnOut, seqBusy}, 32'd3);

    // R10: sleep during wait is deferred
    pulseSleep();
    check("R10 held during wait", {30'd0, pmicEnOut, seqBusy}, 32'd3);
    step(2);
    check("R10 still waiting", {31'd0, seqBusy}, 32'd1);
    pulseOk();
    check("R10 active first", {31'd0, pmicActive}, 32'd1);
    step();
    check("R10 then off", {31'd0, pmicEnOut}, 32'd0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule